// File: doc/BRIEF.md
# Card Presence Guard

This block watches the two active-low presence contacts of a removable card socket and turns them into a clean presence status. Once per slow tick, nominally every 10 ms, it samples both contacts. A sample is acted on only when it matches the sample taken on the tick before, so contact bounce that lasts shorter than one tick never reaches the status flags. A confirmed removal also forces the socket into a safe condition: card power off, card reset asserted and the data bus released to high impedance. It also marks the card as needing a fresh initialisation.

The same tick drives a shared timeout counter that the host's sequencing logic uses for its waits. The client loads the counter synchronously. Each tick then takes one off, and the counter stops at zero. The host starts its power-up and initialisation sequence once the no-card flag drops. It reports a finished initialisation with a one-cycle pulse.

The slot controller has two states. `SLOT_EMPTY` holds power off, reset asserted and the bus floated, and it raises the no-card flag. `SLOT_OCCUPIED` turns power on, releases reset and drives the bus. Transition `EMPTY_TO_OCCUPIED` happens on a stable sample with both contacts low. Transition `OCCUPIED_TO_EMPTY` happens on a stable sample with either contact high. A stable absent sample in `SLOT_EMPTY` keeps that state and sets the not-initialised flag again. Every other cycle holds the current state.

Top module: `card_presence_guard`

## Requirements
- R1: After reset, no_card_o=1, not_init_o=1, pwr_en_o=0, card_rst_n_o=0, bus_float_o=1 and tmo_cnt_o=0. The stored previous sample is all ones, so the first tick after reset can never confirm a card.
- R2: The contacts are sampled only in cycles where tick_i=1. Contact changes between ticks do not affect any output or the stored previous sample.
- R3: A sample is accepted only when it equals the sample from the previous tick. A value seen on a single tick changes no flag.
- R4: A stable sample with cd_n_i[0]=1 or cd_n_i[1]=1 (contact open) sets no_card_o=1 and not_init_o=1 from the clock edge of that tick.
- R5: On a confirmed absence, pwr_en_o=0, card_rst_n_o=0 and bus_float_o=1 from the clock edge of that tick.
- R6: A stable sample with cd_n_i=2'b00 clears no_card_o and sets pwr_en_o=1, card_rst_n_o=1 and bus_float_o=0. It leaves not_init_o unchanged.
- R7: A pulse on init_done_i clears not_init_o only while no_card_o=0. If the pulse comes in the same cycle as a confirmed absence, the absence wins and not_init_o=1.
- R8: Each tick decrements tmo_cnt_o by one. At zero the counter holds at zero.
- R9: When tmo_load_i=1, tmo_cnt_o takes tmo_value_i on the next edge. This holds even when tick_i=1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous-release reset |
| tick_i | input | 1 | One-cycle pulse per sampling interval (10 ms) |
| cd_n_i | input | N_DETECT | Presence contacts, 1 = open |
| init_done_i | input | 1 | Pulse: host finished card initialisation |
| tmo_load_i | input | 1 | Load the timeout counter |
| tmo_value_i | input | TMO_W | Value to load |
| no_card_o | output | 1 | Socket is confirmed empty |
| not_init_o | output | 1 | Card still needs initialisation |
| pwr_en_o | output | 1 | Card power enable |
| card_rst_n_o | output | 1 | Card reset, active low |
| bus_float_o | output | 1 | Release the card data bus to high impedance |
| tmo_cnt_o | output | TMO_W | Timeout counter value |

## Verification
The assertions assume that tick_i is already a single-cycle pulse in the clock domain and that cd_n_i is synchronous to clk. Contact synchronisation is the job of whatever feeds the block. The stimulus changes every input on the falling edge, and tick_i is only ever high for one cycle. The bench checks the outputs one nanosecond after the rising edge. Glitches are modelled as contact values that last for a single tick, or that change only between ticks. This keeps every stimulus inside the synchronous, one-cycle-tick model.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

    typedef enum logic [0:0] {
        SLOT_EMPTY    = 1'b0,
        SLOT_OCCUPIED = 1'b1
    } slot_state_e;

    typedef struct packed {
        logic pwr_en;
        logic card_rst_n;
        logic bus_float;
    } card_drive_t;

    localparam card_drive_t DRIVE_SAFE   = '{pwr_en: 1'b0, card_rst_n: 1'b0, bus_float: 1'b1};
    localparam card_drive_t DRIVE_ACTIVE = '{pwr_en: 1'b1, card_rst_n: 1'b1, bus_float: 1'b0};

endpackage

// File: rtl/cdg_sampler.sv
module cdg_sampler #(
    parameter int N_LINES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [N_LINES-1:0] cd_n_i,
    output logic               absent_o,
    output logic               present_o
);

    localparam logic [N_LINES-1:0] NO_CARD_PATTERN = '1;

    logic [N_LINES-1:0] prev_q;
    logic               agree;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= NO_CARD_PATTERN;
        end else if (tick_i) begin
            prev_q <= cd_n_i;
        end
    end

    always_comb begin
        agree     = tick_i && (cd_n_i == prev_q);
        absent_o  = agree && (|cd_n_i);
        present_o = agree && !(|cd_n_i);
    end

    AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(prev_q)) else $error("prev sample moved off tick"); // R2

    AST_FIRST_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (cd_n_i != prev_q)) |=> (prev_q == $past(cd_n_i))) else $error("sample not stored"); // R3

endmodule

// File: rtl/cdg_slot_fsm.sv
module cdg_slot_fsm
    import cdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        absent_i,
    input  logic        present_i,
    input  logic        init_done_i,
    output logic        no_card_o,
    output logic        not_init_o,
    output card_drive_t drive_o
);

    slot_state_e state_q, state_d;
    logic        not_init_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY:    if (present_i) state_d = SLOT_OCCUPIED;
            SLOT_OCCUPIED: if (absent_i)  state_d = SLOT_EMPTY;
            default:       state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            not_init_q <= 1'b1;
        end else if (absent_i) begin
            not_init_q <= 1'b1;
        end else if (init_done_i && state_q == SLOT_OCCUPIED) begin
            not_init_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (state_q)
            SLOT_EMPTY: begin
                no_card_o = 1'b1;
                drive_o   = DRIVE_SAFE;
            end
            SLOT_OCCUPIED: begin
                no_card_o = 1'b0;
                drive_o   = DRIVE_ACTIVE;
            end
            default: begin
                no_card_o = 1'b1;
                drive_o   = DRIVE_SAFE;
            end
        endcase
        not_init_o = not_init_q;
    end

    AST_ABSENT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        absent_i |=> (no_card_o && not_init_o)) else $error("absence not flagged"); // R4

    AST_PRESENT_KEEPS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (present_i && !init_done_i) |=> (!no_card_o && not_init_o == $past(not_init_o))) else $error("presence touched init flag"); // R6

    AST_INIT_NEEDS_CARD: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done_i && no_card_o) |=> not_init_o) else $error("init cleared without card"); // R7

endmodule

// File: rtl/cdg_timeout.sv
module cdg_timeout #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= ZERO;
        end else if (load_i) begin
            count_q <= value_i;
        end else if (tick_i && count_q != ZERO) begin
            count_q <= count_q - ONE;
        end
    end

    assign count_o = count_q;

    AST_TMO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(value_i))) else $error("load lost"); // R9

    AST_TMO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && count_o != ZERO) |=> (count_o == $past(count_o) - ONE)) else $error("bad decrement"); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && count_o == ZERO) |=> (count_o == ZERO)) else $error("counter wrapped"); // R8

    AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(count_o)) else $error("counter moved off tick"); // R2

endmodule

// File: rtl/card_presence_guard.sv
module card_presence_guard
    import cdg_pkg::*;
#(
    parameter int N_DETECT = 2,
    parameter int TMO_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [N_DETECT-1:0] cd_n_i,
    input  logic                init_done_i,
    input  logic                tmo_load_i,
    input  logic [TMO_W-1:0]    tmo_value_i,
    output logic                no_card_o,
    output logic                not_init_o,
    output logic                pwr_en_o,
    output logic                card_rst_n_o,
    output logic                bus_float_o,
    output logic [TMO_W-1:0]    tmo_cnt_o
);

    logic        absent_evt;
    logic        present_evt;
    card_drive_t drive;

    cdg_sampler #(.N_LINES(N_DETECT)) sampler_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .cd_n_i    (cd_n_i),
        .absent_o  (absent_evt),
        .present_o (present_evt)
    );

    cdg_slot_fsm slot_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .absent_i    (absent_evt),
        .present_i   (present_evt),
        .init_done_i (init_done_i),
        .no_card_o   (no_card_o),
        .not_init_o  (not_init_o),
        .drive_o     (drive)
    );

    cdg_timeout #(.W(TMO_W)) timeout_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .load_i  (tmo_load_i),
        .value_i (tmo_value_i),
        .count_o (tmo_cnt_o)
    );

    assign pwr_en_o     = drive.pwr_en;
    assign card_rst_n_o = drive.card_rst_n;
    assign bus_float_o  = drive.bus_float;

    AST_SAFE_ON_REMOVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (|cd_n_i) && $past(tick_i) == 1'b0 && absent_evt) |=> (!pwr_en_o && !card_rst_n_o && bus_float_o)) else $error("socket not made safe"); // R5

    AST_SAFE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        absent_evt |=> (no_card_o && !pwr_en_o && bus_float_o)) else $error("empty socket powered"); // R5

endmodule

// File: tb/card_presence_guard_tb_top.sv
module card_presence_guard_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] cd_n_i = 2'b11;
    logic       init_done_i = 1'b0;
    logic       tmo_load_i = 1'b0;
    logic [7:0] tmo_value_i = 8'd0;
    logic       no_card_o, not_init_o, pwr_en_o, card_rst_n_o, bus_float_o;
    logic [7:0] tmo_cnt_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    card_presence_guard #(.N_DETECT(2), .TMO_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cd_n_i(cd_n_i),
        .init_done_i(init_done_i), .tmo_load_i(tmo_load_i), .tmo_value_i(tmo_value_i),
        .no_card_o(no_card_o), .not_init_o(not_init_o), .pwr_en_o(pwr_en_o),
        .card_rst_n_o(card_rst_n_o), .bus_float_o(bus_float_o), .tmo_cnt_o(tmo_cnt_o)
    );

    // {tick, cd[1:0], done, load, value[7:0], no_card, not_init, pwr, count[7:0]}
    localparam int NV = 18;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 2'b00, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 8'd0}, // R3 first sample only
        {1'b0, 2'b00, 1'b0, 1'b1, 8'd5, 1'b1, 1'b1, 1'b0, 8'd5}, // R9 load
        {1'b1, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1, 1'b1, 8'd4}, // R6 R8
        {1'b0, 2'b00, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 8'd4}, // R7
        {1'b0, 2'b01, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 8'd4}, // R2
        {1'b1, 2'b01, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 8'd3}, // R3 glitch
        {1'b1, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 8'd2}, // R3
        {1'b1, 2'b10, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 8'd1}, // R3
        {1'b1, 2'b10, 1'b0, 1'b1, 8'd9, 1'b1, 1'b1, 1'b0, 8'd9}, // R4 R5 R9
        {1'b1, 2'b10, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 8'd8}, // R4
        {1'b0, 2'b10, 1'b1, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 8'd8}, // R7 ignored
        {1'b1, 2'b00, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 8'd7}, // R3
        {1'b1, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1, 1'b1, 8'd6}, // R6 keeps flag
        {1'b1, 2'b11, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 8'd5}, // R7
        {1'b1, 2'b11, 1'b1, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 8'd4}, // R7 removal wins
        {1'b0, 2'b11, 1'b0, 1'b1, 8'd1, 1'b1, 1'b1, 1'b0, 8'd1}, // R9
        {1'b1, 2'b11, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 8'd0}, // R8
        {1'b1, 2'b11, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 8'd0}  // R8 floor
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic [1:0] cd, input logic done,
                        input logic ld, input logic [7:0] val);
        @(negedge clk);
        tick_i = t; cd_n_i = cd; init_done_i = done; tmo_load_i = ld; tmo_value_i = val;
        @(posedge clk);
        #1;
        tick_i = 1'b0; init_done_i = 1'b0; tmo_load_i = 1'b0;
    endtask

    task automatic check_drive(input string tag, input logic exp_pwr);
        check({tag, " pwr_en"}, pwr_en_o, exp_pwr);
        check({tag, " card_rst_n"}, card_rst_n_o, exp_pwr);
        check({tag, " bus_float"}, bus_float_o, !exp_pwr);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 no_card", no_card_o, 1);
        check("R1 not_init", not_init_o, 1);
        check("R1 tmo_cnt", tmo_cnt_o, 0);
        check_drive("R1", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][23], VEC[i][22:21], VEC[i][20], VEC[i][19], VEC[i][18:11]);
            check($sformatf("R3 R4 R6 vec%0d no_card", i), no_card_o, VEC[i][10]);
            check($sformatf("R4 R7 vec%0d not_init", i), not_init_o, VEC[i][9]);
            check_drive($sformatf("R5 R6 vec%0d", i), VEC[i][8]);
            check($sformatf("R8 R9 vec%0d tmo_cnt", i), tmo_cnt_o, VEC[i][7:0]);
        end

        // R6 card confirmed again
        step(1'b1, 2'b00, 1'b0, 1'b0, 8'd0);
        step(1'b1, 2'b00, 1'b0, 1'b0, 8'd0);
        check("R6 present", no_card_o, 0);

        // R2 contacts open between ticks leave state and stored sample alone
        for (int k = 0; k < 10; k++) begin
            step(1'b0, 2'b11, 1'b0, 1'b0, 8'd0);
            check("R2 no_card off tick", no_card_o, 0);
        end
        check_drive("R2", 1'b1);
        step(1'b1, 2'b00, 1'b0, 1'b0, 8'd0);
        check("R2 stored sample kept", no_card_o, 0);

        // R1 mid-run reset clears stored sample to no-card pattern
        step(1'b0, 2'b00, 1'b0, 1'b1, 8'd33);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset no_card", no_card_o, 1);
        check("R1 reset not_init", not_init_o, 1);
        check("R1 reset tmo_cnt", tmo_cnt_o, 0);
        check_drive("R1 reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 2'b00, 1'b0, 1'b0, 8'd0);
        check("R1 first tick not accepted", no_card_o, 1);
        step(1'b1, 2'b00, 1'b0, 1'b0, 8'd0);
        check("R3 second tick accepted", no_card_o, 0);
        check("R6 not_init after reset", not_init_o, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule